// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the byte-wide programming front end of a four-channel DMA controller. Software loads each channel's 16-bit base address and 16-bit base count over an 8-bit bus. A single byte pointer, shared by every channel register access, decides whether an access hits the low byte or the high byte. The block also holds a command register, a mode byte per channel, a per-channel mask and a status byte. It answers reads of the live transfer position for each channel.

Accesses arrive as write or read strobes with a 4-bit port index and a space select. The select picks either the channel register space or the control register space. The transfer engine sits outside the block and talks to it through four sets of per-channel pulses: transfer steps, terminal-count events, request raises and request drops. In return it sees the mode, mask and command values as outputs. Read data is combinational from the index in the strobe cycle. Every state change, including the side effects of a read, takes place on the clock edge that ends that cycle.

Top module: `dma_regif`

## Requirements
- R1: A synchronous reset leaves every mask bit set, status, command, mode bytes, base registers and transfer counts at zero, and the byte pointer at the low byte.
- R2: In channel space, index bit 0 selects address (0) or count (1) and index bits 2:1 select the channel. Channel-space indices 8 to 15 are ignored: no register changes, the pointer does not toggle, and reads return 0.
- R3: Every valid channel-space access, read or write, uses the byte pointer (0 = low byte, 1 = high byte) and then toggles it.
- R4: A high-byte write to either base register of a channel sets that channel's current address to its base address, including a high byte written in that same access, and clears its transfer count.
- R5: A channel address read returns current address plus transfer count, or minus it when mode bit 5 is 1. A count read returns base count minus transfer count. Both are taken modulo 2^16.
- R6: A control write to index 0 loads the command register only if no data bit other than bit 2 is set; otherwise the command is unchanged.
- R7: A control write to index 3 stores the whole data byte as the mode of the channel in data bits 1:0.
- R8: Control index 2 sets (data bit 2 = 1) or clears one mask bit, for the channel in data bits 1:0. Index 6 clears all mask bits. Index 7 loads the mask from data bits 3:0.
- R9: Control index 4 returns the byte pointer to the low byte. Control index 5 clears the pointer, sets all mask bits and clears status and command, but keeps modes and channel registers.
- R10: Status bits 7:4 are request flags, set by req_set and cleared by req_clr, with set winning. Bits 3:0 are terminal-count flags, set by tc_set. A status read returns the byte and then clears bits 3:0 only, unless a tc_set in that cycle sets them again.
- R11: A control read of index 0 returns status, index 1 returns the mask in bits 3:0, and any other index returns 0. Control writes to index 1 or to indices 8 to 15 change nothing. rdata is 0 when no read is strobed.
- R12: A pulse on xfer_step[c] adds one (mod 2^16) to channel c's transfer count, unless the same cycle reloads that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe, one access per cycle |
| rd_stb | input | 1 | Read strobe; its side effects are suppressed when wr_stb is also high |
| ctl_sel | input | 1 | 1 selects control space, 0 selects channel space |
| port_idx | input | 4 | Register index within the selected space |
| wdata | input | 8 | Write data |
| xfer_step | input | 4 | Per-channel transfer-count increment pulses |
| tc_set | input | 4 | Per-channel terminal-count event pulses |
| req_set | input | 4 | Per-channel request raise pulses |
| req_clr | input | 4 | Per-channel request drop pulses |
| rdata | output | 8 | Read data, combinational in the strobe cycle |
| mode_all | output | 32 | Mode bytes, channel c in bits 8c+7:8c |
| mask_all | output | 4 | Channel mask bits |
| command_q | output | 8 | Command register |

## Verification
Read data is due in the same cycle as its strobe, because it is decoded combinationally from registered state. Every register effect of a write, a read side effect or an engine pulse is due one clock edge later. The bench drives inputs at the falling edge and samples all outputs 1 ns later. It compares them with a behavioural model holding the state from before the next rising edge, and it updates that model only after the edge. A read placed right after a write therefore sees the write's effect exactly one cycle later, and the bench expects it there.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int IDX_W  = 4;

  // control-space write indices
  localparam logic [IDX_W-1:0] CTL_COMMAND    = 4'd0;
  localparam logic [IDX_W-1:0] CTL_MASK_ONE   = 4'd2;
  localparam logic [IDX_W-1:0] CTL_MODE       = 4'd3;
  localparam logic [IDX_W-1:0] CTL_FF_CLEAR   = 4'd4;
  localparam logic [IDX_W-1:0] CTL_MASTER_RST = 4'd5;
  localparam logic [IDX_W-1:0] CTL_MASK_NONE  = 4'd6;
  localparam logic [IDX_W-1:0] CTL_MASK_LOAD  = 4'd7;
  // control-space read indices
  localparam logic [IDX_W-1:0] CTL_RD_STATUS  = 4'd0;
  localparam logic [IDX_W-1:0] CTL_RD_MASK    = 4'd1;

  localparam logic [BYTE_W-1:0] CMD_ALLOWED = 8'h04;
  localparam int MODE_DIR_BIT = 5;
  localparam int MASK_VAL_BIT = 2;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w, input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dma_regif_ctrl.sv
module dma_regif_ctrl
  import dma_regif_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic                  rd_stb,
  input  logic                  ctl_sel,
  input  logic [IDX_W-1:0]      port_idx,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  chan_acc,
  input  logic [NCH-1:0]        tc_set,
  input  logic [NCH-1:0]        req_set,
  input  logic [NCH-1:0]        req_clr,
  output logic                  ff_q,
  output logic [NCH-1:0]        mask_q,
  output logic [BYTE_W-1:0]     cmd_q,
  output logic [2*NCH-1:0]      status_q,
  output logic [NCH*BYTE_W-1:0] mode_flat
);
  localparam int CH_W = $clog2(NCH);

  logic ctl_wr, st_rd, mrst;
  logic [2*NCH-1:0] st_next;

  assign ctl_wr = wr_stb && ctl_sel;
  assign st_rd  = rd_stb && !wr_stb && ctl_sel && (port_idx == CTL_RD_STATUS);
  assign mrst   = ctl_wr && (port_idx == CTL_MASTER_RST);

  // shared byte pointer
  always_ff @(posedge clk) begin
    if (rst || mrst || (ctl_wr && port_idx == CTL_FF_CLEAR)) ff_q <= 1'b0;
    else if (chan_acc)                                      ff_q <= ~ff_q;
  end

  // command: only the allowed bit may be set
  always_ff @(posedge clk) begin
    if (rst || mrst) cmd_q <= '0;
    else if (ctl_wr && port_idx == CTL_COMMAND && (wdata & ~CMD_ALLOWED) == '0) cmd_q <= wdata;
  end

  // mask register
  always_ff @(posedge clk) begin
    if (rst || mrst) mask_q <= '1;
    else if (ctl_wr) begin
      case (port_idx)
        CTL_MASK_ONE:  mask_q[wdata[CH_W-1:0]] <= wdata[MASK_VAL_BIT];
        CTL_MASK_NONE: mask_q <= '0;
        CTL_MASK_LOAD: mask_q <= wdata[NCH-1:0];
        default:       mask_q <= mask_q;
      endcase
    end
  end

  // per-channel mode bytes
  for (genvar g = 0; g < NCH; g++) begin : g_mode
    logic [BYTE_W-1:0] mode_r;
    always_ff @(posedge clk) begin
      if (rst) mode_r <= '0;
      else if (ctl_wr && port_idx == CTL_MODE && wdata[CH_W-1:0] == CH_W'(g)) mode_r <= wdata;
    end
    assign mode_flat[g*BYTE_W +: BYTE_W] = mode_r;
  end

  // status: upper half request flags, lower half terminal-count flags
  always_comb begin
    st_next = status_q;
    if (st_rd) st_next[NCH-1:0] = '0;
    st_next[NCH-1:0]     = st_next[NCH-1:0] | tc_set;
    st_next[2*NCH-1:NCH] = (st_next[2*NCH-1:NCH] & ~req_clr) | req_set;
  end

  always_ff @(posedge clk) begin
    if (rst || mrst) status_q <= '0;
    else             status_q <= st_next;
  end

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && port_idx == CTL_COMMAND && (wdata & ~CMD_ALLOWED) != '0) |=> $stable(cmd_q));

  assert_master_rst_R9: assert property (@(posedge clk) disable iff (rst)
    mrst |=> ((&mask_q) && status_q == '0 && cmd_q == '0 && !ff_q));

  assert_ff_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    chan_acc |=> (ff_q != $past(ff_q)));

  assert_req_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (st_rd && req_set == '0 && req_clr == '0) |=> (status_q[2*NCH-1:NCH] == $past(status_q[2*NCH-1:NCH])));

  assert_tc_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (st_rd && tc_set == '0) |=> (status_q[NCH-1:0] == '0));
endmodule

// File: rtl/dma_regif_chans.sv
module dma_regif_chans
  import dma_regif_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic              ctl_sel,
  input  logic [IDX_W-1:0]  port_idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ff_q,
  input  logic [NCH-1:0]    xfer_step,
  input  logic [NCH-1:0]    dir_dec,
  output logic              chan_acc,
  output logic [BYTE_W-1:0] chan_rd
);
  localparam int CH_W = $clog2(NCH);

  logic            chan_hit;
  logic [CH_W-1:0] ch_sel;
  logic            reg_sel;
  logic [WORD_W-1:0] addr_view [NCH];
  logic [WORD_W-1:0] cnt_view  [NCH];
  logic [WORD_W-1:0] word_sel;

  assign chan_hit = !ctl_sel && ((port_idx >> (CH_W + 1)) == '0);
  assign ch_sel   = port_idx[CH_W:1];
  assign reg_sel  = port_idx[0];
  assign chan_acc = chan_hit && (wr_stb || rd_stb);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [WORD_W-1:0] base_a, base_c, cur_a, xcnt;
    logic hit_w, reload;

    assign hit_w  = wr_stb && chan_hit && (ch_sel == CH_W'(g));
    assign reload = hit_w && ff_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_a <= '0;
        base_c <= '0;
        cur_a  <= '0;
        xcnt   <= '0;
      end else begin
        if (hit_w) begin
          if (!reg_sel) begin
            if (ff_q) base_a[WORD_W-1:BYTE_W] <= wdata;
            else      base_a[BYTE_W-1:0]      <= wdata;
          end else begin
            if (ff_q) base_c[WORD_W-1:BYTE_W] <= wdata;
            else      base_c[BYTE_W-1:0]      <= wdata;
          end
        end
        if (reload) begin
          cur_a <= reg_sel ? base_a : {wdata, base_a[BYTE_W-1:0]};
          xcnt  <= '0;
        end else if (xfer_step[g]) begin
          xcnt <= xcnt + 1'b1;
        end
      end
    end

    assign addr_view[g] = dir_dec[g] ? (cur_a - xcnt) : (cur_a + xcnt);
    assign cnt_view[g]  = base_c - xcnt;

    assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
      reload |=> (xcnt == '0 && cur_a == base_a));
  end

  assign word_sel = reg_sel ? cnt_view[ch_sel] : addr_view[ch_sel];
  assign chan_rd  = chan_hit ? pick_byte(word_sel, ff_q) : '0;
endmodule

// File: rtl/dma_regif.sv
module dma_regif
  import dma_regif_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic                  rd_stb,
  input  logic                  ctl_sel,
  input  logic [IDX_W-1:0]      port_idx,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic [NCH-1:0]        xfer_step,
  input  logic [NCH-1:0]        tc_set,
  input  logic [NCH-1:0]        req_set,
  input  logic [NCH-1:0]        req_clr,
  output logic [BYTE_W-1:0]     rdata,
  output logic [NCH*BYTE_W-1:0] mode_all,
  output logic [NCH-1:0]        mask_all,
  output logic [BYTE_W-1:0]     command_q
);
  logic              ff_q, chan_acc;
  logic [2*NCH-1:0]  status_q;
  logic [BYTE_W-1:0] chan_rd;
  logic [NCH-1:0]    dir_dec;

  dma_regif_ctrl #(.NCH(NCH)) i_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .ctl_sel(ctl_sel),
    .port_idx(port_idx), .wdata(wdata), .chan_acc(chan_acc),
    .tc_set(tc_set), .req_set(req_set), .req_clr(req_clr),
    .ff_q(ff_q), .mask_q(mask_all), .cmd_q(command_q), .status_q(status_q),
    .mode_flat(mode_all)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_dir
    assign dir_dec[g] = mode_all[g*BYTE_W + MODE_DIR_BIT];
  end

  dma_regif_chans #(.NCH(NCH)) i_chans (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .ctl_sel(ctl_sel),
    .port_idx(port_idx), .wdata(wdata), .ff_q(ff_q), .xfer_step(xfer_step),
    .dir_dec(dir_dec), .chan_acc(chan_acc), .chan_rd(chan_rd)
  );

  always_comb begin
    rdata = '0;
    if (rd_stb && !wr_stb) begin
      if (ctl_sel) begin
        if (port_idx == CTL_RD_STATUS)    rdata = BYTE_W'(status_q);
        else if (port_idx == CTL_RD_MASK) rdata = BYTE_W'(mask_all);
      end else begin
        rdata = chan_rd;
      end
    end
  end

  assert_unused_wr_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && ctl_sel && (port_idx == 4'd1 || port_idx[3])) |=>
      ($stable(mask_all) && $stable(command_q) && $stable(mode_all)));

  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb) |-> (rdata == '0));
endmodule

// File: tb/test_dma_regif.sv
module test_dma_regif;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       b_rst, b_wr, b_rd, b_ctl;
  logic [3:0] b_idx, b_xs, b_tc, b_rs, b_rc;
  logic [7:0] b_data;
  logic [7:0] rdata, command_q;
  logic [31:0] mode_all;
  logic [3:0]  mask_all;

  dma_regif i_dma_regif (
    .clk(clk), .rst(b_rst), .wr_stb(b_wr), .rd_stb(b_rd), .ctl_sel(b_ctl),
    .port_idx(b_idx), .wdata(b_data), .xfer_step(b_xs), .tc_set(b_tc),
    .req_set(b_rs), .req_clr(b_rc), .rdata(rdata), .mode_all(mode_all),
    .mask_all(mask_all), .command_q(command_q)
  );

  int total = 0, bad = 0;
  int m_ff, m_mask, m_cmd, m_st;
  int m_ba[4], m_bc[4], m_cur[4], m_xc[4], m_mode[4];

  task automatic model_reset(bit full);
    m_ff = 0; m_mask = 15; m_st = 0; m_cmd = 0;
    if (full) for (int c = 0; c < 4; c++) begin
      m_ba[c] = 0; m_bc[c] = 0; m_cur[c] = 0; m_xc[c] = 0; m_mode[c] = 0;
    end
  endtask

  function automatic int exp_rdata();
    int w, ch;
    if (!b_rd || b_wr) return 0;
    if (b_ctl) begin
      if (b_idx == 0) return m_st;
      if (b_idx == 1) return m_mask;
      return 0;
    end
    if (b_idx >= 8) return 0;
    ch = b_idx >> 1;
    if (b_idx[0]) w = m_bc[ch] - m_xc[ch];
    else if (m_mode[ch] & 32'h20) w = m_cur[ch] - m_xc[ch];
    else w = m_cur[ch] + m_xc[ch];
    w = w & 16'hFFFF;
    return m_ff ? (w >> 8) : (w & 8'hFF);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    int ch, r;
    bit [3:0] reload;
    reload = 0;
    if (b_rst) begin model_reset(1); return; end
    if (!b_ctl && b_idx < 8) begin
      ch = b_idx >> 1; r = b_idx & 1;
      if (b_wr) begin
        if (m_ff) begin
          if (r == 0) m_ba[ch] = (m_ba[ch] & 8'hFF) | (b_data << 8);
          else        m_bc[ch] = (m_bc[ch] & 8'hFF) | (b_data << 8);
          m_cur[ch] = m_ba[ch]; reload[ch] = 1;
        end else begin
          if (r == 0) m_ba[ch] = (m_ba[ch] & 16'hFF00) | b_data;
          else        m_bc[ch] = (m_bc[ch] & 16'hFF00) | b_data;
        end
      end
      if (b_wr || b_rd) m_ff = m_ff ^ 1;
    end
    if (b_ctl && b_wr && b_idx == 5) m_st = 0;
    else begin
      if (b_ctl && b_rd && !b_wr && b_idx == 0) m_st = m_st & 8'hF0;
      m_st = m_st | b_tc;
      m_st = ((m_st & ~(b_rc << 4)) | (b_rs << 4)) & 8'hFF;
    end
    if (b_ctl && b_wr) begin
      case (b_idx)
        0: if ((b_data & 8'hFB) == 0) m_cmd = b_data;
        2: if (b_data[2]) m_mask = m_mask | (1 << b_data[1:0]);
           else           m_mask = m_mask & ~(1 << b_data[1:0]) & 15;
        3: m_mode[b_data[1:0]] = b_data;
        4: m_ff = 0;
        5: model_reset(0);
        6: m_mask = 0;
        7: m_mask = b_data & 15;
        default: ;
      endcase
    end
    for (int c = 0; c < 4; c++)
      if (reload[c]) m_xc[c] = 0;
      else if (b_xs[c]) m_xc[c] = (m_xc[c] + 1) & 16'hFFFF;
  endtask

  task automatic idle_inputs();
    b_wr = 0; b_rd = 0; b_ctl = 0; b_idx = 0; b_data = 0;
    b_xs = 0; b_tc = 0; b_rs = 0; b_rc = 0;
  endtask

  // inputs are set at a falling edge; outputs sampled 1 ns later
  task automatic tick(string tag);
    #1;
    check(tag, "rdata", rdata, exp_rdata());
    check(tag, "mask_all", mask_all, m_mask);
    check(tag, "command_q", command_q, m_cmd);
    check(tag, "mode_all", mode_all, {m_mode[3][7:0], m_mode[2][7:0], m_mode[1][7:0], m_mode[0][7:0]});
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr_ctl(int idx, int d, string tag);
    b_wr = 1; b_ctl = 1; b_idx = idx[3:0]; b_data = d[7:0]; tick(tag);
  endtask
  task automatic rd_ctl(int idx, string tag);
    b_rd = 1; b_ctl = 1; b_idx = idx[3:0]; tick(tag);
  endtask
  task automatic wr_ch(int idx, int d, string tag);
    b_wr = 1; b_ctl = 0; b_idx = idx[3:0]; b_data = d[7:0]; tick(tag);
  endtask
  task automatic rd_ch(int idx, string tag);
    b_rd = 1; b_ctl = 0; b_idx = idx[3:0]; tick(tag);
  endtask
  task automatic pulses(int xs, int tc, int rs, int rc, string tag);
    b_xs = xs[3:0]; b_tc = tc[3:0]; b_rs = rs[3:0]; b_rc = rc[3:0]; tick(tag);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    model_reset(1);
    b_rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    tick("R1");
    b_rst = 0;
    rd_ctl(1, "R1"); rd_ctl(0, "R1"); rd_ch(0, "R1"); rd_ch(0, "R1");

    // command filter
    wr_ctl(0, 8'h04, "R6"); wr_ctl(0, 8'h10, "R6"); wr_ctl(0, 8'h81, "R6");
    wr_ctl(0, 8'h00, "R6"); wr_ctl(0, 8'h04, "R6");

    // modes
    wr_ctl(3, 8'h49, "R7"); wr_ctl(3, 8'h56, "R7"); wr_ctl(3, 8'h22, "R7"); wr_ctl(3, 8'hC7, "R7");

    // channel 1 base registers
    wr_ch(2, 8'h34, "R3"); wr_ch(2, 8'h12, "R4");
    wr_ch(3, 8'h78, "R3"); wr_ch(3, 8'h56, "R4");
    rd_ch(2, "R5"); rd_ch(2, "R5"); rd_ch(3, "R5"); rd_ch(3, "R5");
    for (int k = 0; k < 3; k++) pulses(4'b0010, 0, 0, 0, "R12");
    rd_ch(2, "R12"); rd_ch(2, "R12"); rd_ch(3, "R5"); rd_ch(3, "R5");
    // high-byte count write reloads and clears count
    wr_ch(3, 8'h00, "R4"); pulses(4'b0010, 0, 0, 0, "R12"); wr_ch(3, 8'h01, "R4");
    rd_ch(2, "R4"); rd_ch(2, "R4");

    // channel 2 decrement with wrap
    wr_ch(4, 8'h10, "R4"); wr_ch(4, 8'h00, "R4");
    for (int k = 0; k < 32; k++) pulses(4'b0100, 0, 0, 0, "R5");
    rd_ch(4, "R5"); rd_ch(4, "R5"); rd_ch(5, "R5"); rd_ch(5, "R5");
    // step and reload in the same cycle
    wr_ch(4, 8'hAA, "R12"); b_xs = 4'b0100; wr_ch(4, 8'h55, "R12");
    rd_ch(4, "R12"); rd_ch(4, "R12");

    // pointer clear mid-pair
    wr_ch(6, 8'h11, "R9"); wr_ctl(4, 0, "R9"); wr_ch(6, 8'h22, "R9"); wr_ch(6, 8'h33, "R9");
    rd_ch(6, "R9"); rd_ch(6, "R9");

    // ignored channel indices
    wr_ch(9, 8'hEE, "R2"); rd_ch(8, "R2"); rd_ch(15, "R2"); rd_ch(0, "R2"); rd_ch(0, "R2");
    rd_ch(7, "R2"); rd_ch(7, "R2");

    // mask operations
    wr_ctl(6, 0, "R8"); wr_ctl(2, 8'h06, "R8"); rd_ctl(1, "R8"); wr_ctl(2, 8'h02, "R8");
    wr_ctl(7, 8'hF9, "R8"); rd_ctl(1, "R8"); wr_ctl(2, 8'h04, "R8");

    // status
    pulses(0, 4'b0101, 4'b1010, 0, "R10"); rd_ctl(0, "R10"); rd_ctl(0, "R10");
    pulses(0, 0, 4'b0001, 4'b0011, "R10"); rd_ctl(0, "R10");
    b_tc = 4'b1000; rd_ctl(0, "R10"); rd_ctl(0, "R10");

    // unused control indices
    wr_ctl(1, 8'hFF, "R11"); wr_ctl(9, 8'h00, "R11"); wr_ctl(12, 8'h00, "R11");
    rd_ctl(2, "R11"); rd_ctl(9, "R11"); rd_ctl(1, "R11");
    b_wr = 1; b_rd = 1; b_ctl = 1; b_idx = 0; b_data = 8'h00; b_tc = 4'b0001; tick("R11");
    rd_ctl(0, "R11");

    // master reset
    pulses(0, 4'b0011, 4'b1100, 0, "R9"); wr_ch(0, 8'h01, "R9");
    wr_ctl(5, 0, "R9"); rd_ctl(0, "R9"); rd_ctl(1, "R9"); rd_ch(2, "R9"); rd_ch(2, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule